// File: doc/BRIEF.md
# Transmit Pause Quantum Timer

This block enforces flow-control pauses on an Ethernet transmitter. A separate frame checker recognises a valid pause request and sends a one-cycle pulse with the requested pause time. The timer stores that time in a 16-bit count. It counts the value down in pause quanta of 512 bit times, which is 128 clocks on a 4-bit datapath. While a pause is in force, it raises a hold level that stops the transmitter from starting a new frame.

Configuration inputs select three things. The first is whether pausing applies at all. The second is whether the link runs full duplex. A request arriving in half duplex is dropped. The third is a test mode in which every permitted clock counts as a whole quantum. A transmitter-idle input gates the countdown, but only when pausing is enabled. A one-cycle interrupt marks the moment the count is decremented to zero, and it can be masked.

Top module: `pause_quantum_timer`

## Requirements
- R1: While reset is asserted and after it is released, with no load, `pause_count` is 0 and `tx_hold` and `zero_irq` are 0.
- R2: A `load_valid` pulse while `cfg_full_duplex`=1 sets `pause_count` to `load_value` on the following cycle. This holds whatever the previous count was and whatever the value of `cfg_pause_en`.
- R3: A `load_valid` pulse while `cfg_full_duplex`=0 has no effect on `pause_count`.
- R4: `tx_hold` is 1 exactly when `cfg_pause_en`=1, `cfg_full_duplex`=1 and `pause_count` is non-zero. It does not depend on `tx_idle`, so a frame already in flight is not cut short.
- R5: With `cfg_test_mode`=0, `pause_count` drops by one after every 128 cycles in which counting is permitted.
- R6: With `cfg_test_mode`=1, `pause_count` drops by one on every cycle in which counting is permitted.
- R7: With `cfg_pause_en`=1, counting is permitted only in cycles where `tx_idle`=1. In other cycles the count and the partial quantum are both frozen.
- R8: With `cfg_pause_en`=0, counting is permitted in every cycle, whatever the value of `tx_idle`.
- R9: When a decrement takes `pause_count` from 1 to 0 and `irq_mask`=1, `zero_irq` is 1 for exactly the following cycle. With `irq_mask`=0, no pulse is produced.
- R10: The count never goes below zero. A load of zero produces no `zero_irq`.
- R11: When a load and a decrement fall in the same cycle, the load wins. Every load restarts the partial quantum, so the next decrement comes a full 128 permitted cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pause_en | input | 1 | 1 = honour pauses and gate countdown on transmitter idle |
| cfg_full_duplex | input | 1 | 1 = full duplex; loads accepted |
| cfg_test_mode | input | 1 | 1 = one decrement per permitted cycle |
| tx_idle | input | 1 | 1 = no frame being transmitted |
| load_valid | input | 1 | One-cycle valid pause request |
| load_value | input | 16 | Requested pause time in quanta |
| irq_mask | input | 1 | 1 = zero interrupt enabled |
| tx_hold | output | 1 | 1 = do not start a new frame |
| pause_count | output | 16 | Current pause count |
| zero_irq | output | 1 | One-cycle pulse on decrement to zero |

## Verification
The bench targets several corner cases, each paired with the failure it would expose.
- A load landing on the same cycle as a decrement: a design that let the decrement win would show the count one lower than loaded.
- A load arriving mid-quantum: if the prescaler were not restarted, the next decrement would come early.
- Long stretches with the transmitter busy and pausing enabled: a design that ignored idleness would keep counting, while one that cleared the partial quantum there would count late.
- Loads of zero, loads in half duplex and masked expiries: a wrong design would emit spurious interrupts, accept the ignored value, or underflow to 0xFFFF.

// File: rtl/pqt_pkg.sv
package pqt_pkg;
  localparam int unsigned PQT_CNT_W_DEF   = 16;
  localparam int unsigned PQT_QUANTUM_DEF = 128;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_LOAD = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;
endpackage

// File: rtl/pqt_reset_sync.sv
module pqt_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pqt_prescaler.sv
module pqt_prescaler #(
  parameter int unsigned QUANTUM = 128,
  localparam int unsigned PW = (QUANTUM > 1) ? $clog2(QUANTUM) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic test_mode,
  output logic tick
);
  logic [PW-1:0] phase_q, phase_d;
  logic          wrap;
  logic          phase_en;

  assign wrap = (phase_q == PW'(QUANTUM - 1));
  assign tick = run && !restart && (test_mode || wrap);
  assign phase_en = restart || run;

  always_comb begin
    phase_d = phase_q;
    if (restart)                     phase_d = '0;
    else if (run) begin
      if (test_mode || wrap)         phase_d = '0;
      else                           phase_d = phase_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end

  // Partial quantum frozen when counting is not permitted (R7)
  assert_phase_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(phase_q));
  // A restart always gives a clean quantum (R11)
  assert_restart_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q == '0));
endmodule

// File: rtl/pqt_counter.sv
module pqt_counter
  import pqt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_value,
  input  logic             tick,
  input  logic             irq_en,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             irq_q, irq_d;
  logic             nonzero;
  step_e            step;

  assign nonzero = (count_q != '0);

  always_comb begin
    if (load)                 step = STEP_LOAD;
    else if (tick && nonzero) step = STEP_DEC;
    else                      step = STEP_HOLD;
  end

  always_comb begin
    count_d = count_q;
    irq_d   = 1'b0;
    case (step)
      STEP_LOAD: count_d = load_value;
      STEP_DEC: begin
        count_d = count_q - CNT_W'(1);
        irq_d   = irq_en && (count_q == CNT_W'(1));
      end
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (step != STEP_HOLD) count_q <= count_d;
      irq_q <= irq_d;
    end
  end

  assign count = count_q;
  assign irq   = irq_q;

  // Load wins and is taken verbatim (R2, R11)
  assert_load_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count_q == $past(load_value)));
  // Zero stays zero without a load (R10)
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count_q == '0) |=> (count_q == '0));
  // Interrupt only when the count has just reached zero (R9)
  assert_irq_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (count_q == '0 && $past(count_q) == CNT_W'(1)));
endmodule

// File: rtl/pause_quantum_timer.sv
module pause_quantum_timer
  import pqt_pkg::*;
#(
  parameter int unsigned CNT_W   = PQT_CNT_W_DEF,
  parameter int unsigned QUANTUM = PQT_QUANTUM_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_pause_en,
  input  logic             cfg_full_duplex,
  input  logic             cfg_test_mode,
  input  logic             tx_idle,
  input  logic             load_valid,
  input  logic [CNT_W-1:0] load_value,
  input  logic             irq_mask,
  output logic             tx_hold,
  output logic [CNT_W-1:0] pause_count,
  output logic             zero_irq
);
  logic rst_sync_n;
  logic accept_load;
  logic count_permit;
  logic prescale_run;
  logic quantum_tick;

  pqt_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign accept_load  = load_valid && cfg_full_duplex;
  assign count_permit = !cfg_pause_en || tx_idle;
  assign prescale_run = count_permit && (pause_count != '0);

  pqt_prescaler #(.QUANTUM(QUANTUM)) u_pre (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .restart   (accept_load),
    .run       (prescale_run),
    .test_mode (cfg_test_mode),
    .tick      (quantum_tick)
  );

  pqt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (accept_load),
    .load_value (load_value),
    .tick       (quantum_tick),
    .irq_en     (irq_mask),
    .count      (pause_count),
    .irq        (zero_irq)
  );

  assign tx_hold = cfg_pause_en && cfg_full_duplex && (pause_count != '0);

  // Half duplex never raises the count (R3)
  assert_half_duplex_ignored_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_full_duplex |=> (pause_count <= $past(pause_count)));
  // Busy transmitter with pausing enabled freezes the count (R7)
  assert_busy_freezes_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_pause_en && !tx_idle && !accept_load) |=> $stable(pause_count));
  // Hold never asserted with an empty count or in half duplex (R4)
  assert_hold_needs_count_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_hold |-> (pause_count != '0 && cfg_full_duplex));
endmodule

// File: tb/pause_quantum_timer_test.sv
module pause_quantum_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_pause_en = 1'b0;
  logic        cfg_full_duplex = 1'b0;
  logic        cfg_test_mode = 1'b0;
  logic        tx_idle = 1'b1;
  logic        load_valid = 1'b0;
  logic [15:0] load_value = '0;
  logic        irq_mask = 1'b0;
  logic        tx_hold;
  logic [15:0] pause_count;
  logic        zero_irq;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  // reference model state
  int m_cnt = 0;
  int m_pre = 0;
  bit m_irq = 0;

  always #5 clk = ~clk;

  pause_quantum_timer uut (
    .clk(clk), .rst_n(rst_n), .cfg_pause_en(cfg_pause_en),
    .cfg_full_duplex(cfg_full_duplex), .cfg_test_mode(cfg_test_mode),
    .tx_idle(tx_idle), .load_valid(load_valid), .load_value(load_value),
    .irq_mask(irq_mask), .tx_hold(tx_hold), .pause_count(pause_count),
    .zero_irq(zero_irq)
  );

  // Behavioural model, updated on the rising edge from the stable inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_irq = 0;
    end else begin
      m_irq = 0;
      if (load_valid && cfg_full_duplex) begin
        m_cnt = load_value;
        m_pre = 0;
      end else if (m_cnt > 0 && (!cfg_pause_en || tx_idle)) begin
        if (cfg_test_mode || m_pre == 127) begin
          m_pre = 0;
          m_cnt = m_cnt - 1;
          if (m_cnt == 0 && irq_mask) m_irq = 1;
        end else begin
          m_pre = m_pre + 1;
        end
      end
    end
  end

  task automatic check(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  // Compare on every falling edge
  always @(negedge clk) begin
    cycles++;
    check("pause_count", int'(pause_count), m_cnt);
    check("tx_hold", int'(tx_hold), int'(cfg_pause_en && cfg_full_duplex && m_cnt != 0));
    check("zero_irq", int'(zero_irq), int'(m_irq));
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic pulse_load(int v);
    @(negedge clk); #1;
    load_valid = 1'b1;
    load_value = 16'(v);
    @(negedge clk); #1;
    load_valid = 1'b0;
  endtask

  initial begin
    cur_req = "R1";
    step(4);
    @(negedge clk); #1 rst_n = 1'b1;
    step(6);
    check("reset count", int'(pause_count), 0);

    cur_req = "R2";
    cfg_full_duplex = 1; cfg_pause_en = 1; tx_idle = 1; irq_mask = 1;
    pulse_load(3);
    check("loaded", int'(pause_count), 3);

    cur_req = "R5";
    step(3 * 128 + 4);
    check("expired", int'(pause_count), 0);

    cur_req = "R4";
    pulse_load(2);
    tx_idle = 0;
    step(20);
    check("hold while busy", int'(tx_hold), 1);

    cur_req = "R7";
    step(200);
    check("frozen count", int'(pause_count), 2);
    tx_idle = 1;
    step(100);
    tx_idle = 0;
    step(50);
    tx_idle = 1;
    step(300);

    cur_req = "R6";
    cfg_test_mode = 1;
    pulse_load(5);
    step(3);
    tx_idle = 0; step(3); tx_idle = 1;
    step(6);
    check("test expiry", int'(pause_count), 0);

    cur_req = "R11";
    pulse_load(4);
    pulse_load(9);
    pulse_load(7);
    step(2);
    cfg_test_mode = 0;
    pulse_load(2);
    step(100);
    pulse_load(2);
    step(130);
    check("restart quantum", int'(pause_count), 1);
    step(140);

    cur_req = "R8";
    cfg_pause_en = 0; tx_idle = 0;
    pulse_load(2);
    check("hold off when disabled", int'(tx_hold), 0);
    step(260);
    check("counted while busy", int'(pause_count), 0);

    cur_req = "R2";
    pulse_load(6);
    step(10);
    pulse_load(1);
    check("overwrite", int'(pause_count), 1);
    step(140);

    cur_req = "R3";
    cfg_full_duplex = 0; cfg_pause_en = 1; tx_idle = 1;
    pulse_load(9);
    step(3);
    check("half duplex load ignored", int'(pause_count), 0);

    cur_req = "R9";
    cfg_full_duplex = 1; irq_mask = 0; cfg_test_mode = 1;
    pulse_load(3);
    step(8);
    irq_mask = 1;

    cur_req = "R10";
    pulse_load(0);
    step(5);
    check("zero load", int'(pause_count), 0);

    cur_req = "R5";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); #1;
      cfg_pause_en    = ($urandom_range(0, 3) != 0);
      cfg_full_duplex = ($urandom_range(0, 7) != 0);
      cfg_test_mode   = ($urandom_range(0, 3) == 0);
      tx_idle         = ($urandom_range(0, 2) != 0);
      irq_mask        = ($urandom_range(0, 1) == 1);
      load_valid      = ($urandom_range(0, 60) == 0);
      load_value      = 16'($urandom_range(0, 4));
    end
    load_valid = 0;
    step(4);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule